// File: doc/BRIEF.md
# Time-of-Day Calendar Counter

This block keeps wall-clock time and date in eight byte-wide registers: seconds, minutes, hours, day of week, day of month, month, two-digit year and century. A 15-bit prescaler counts a 32768 Hz clock-enable pulse. Each time the prescaler wraps, one second is added, and a carry passes on through minutes, hours, the day counters, month, year and century. Month lengths are honoured, and February has 29 days when the two-digit year is a multiple of four.

Software reads and writes the registers through one byte port. Each access is addressed by a 4-bit index, and a read returns its value in the same cycle. Two control registers set the presentation: packed BCD or binary, and 24-hour or 12-hour with a PM flag. They also hold a set bit that freezes the clock while software loads a new time, and a 3-bit divider field that can stop the clock or hold its prescaler in reset. The time is stored internally in binary, so a change of format bits changes only how the stored time is shown.

A read-only update-in-progress bit warns software during the last few prescaler counts before each second rolls over. When the divider leaves reset, the first rollover comes half a second later.

Top module: `tod_calendar`

## Requirements
- R1: Address map: 0 seconds, 1 minutes, 2 hours, 3 day of week (1..7), 4 day of month, 5 month (1..12), 6 year modulo 100, 7 century, 8 control A, 9 control B, 10 flag register, 11 status register. After reset the time reads 00:00:00, weekday 1, day 1, month 1, year 0, century 0. Control A reads 0x26 and control B reads 0x02.
- R2: With control B bit 2 clear, every time register reads and is written as packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R3: With control B bit 2 set, every time register reads and is written as a plain binary number.
- R4: Control B bit 1 set selects 24-hour hours (0..23). With it clear, the hour register holds 1..12 with bit 7 set for PM, and both midnight and noon show as 12. Writes are decoded in the same format.
- R5: While the clock runs, seconds advance by one exactly on the 2^PRESC_W-th enabled tick of each prescaler cycle, and at no other time except by a write.
- R6: A seconds rollover cascades into minutes, hours, weekday (7 wraps to 1), day of month (past the month's last day wraps to 1), month (12 wraps to 1), year (99 wraps to 0) and century. February has 29 days when year mod 4 is 0 and 28 days otherwise. April, June, September and November have 30 days.
- R7: While control B bit 7 (set) is 1, no time register advances, and writes to the time registers take effect directly. A write to control B with bit 7 set stores bit 4 as 0.
- R8: The divider field, control A bits 6:4, lets the clock run only for values 0..2. Values 3..5 stop it. Values 6 and 7 hold the prescaler at zero and keep the update-in-progress bit at 0.
- R9: When a write to control A moves the divider from 6 or 7 to a running value while set is 0, the first rollover occurs after 2^(PRESC_W-1) enabled ticks.
- R10: Control A bit 7 is read-only. It reads 1 exactly while the clock runs and the prescaler is within its last UIP_TICKS counts before rollover.
- R11: The flag register always reads 0x00 and the status register always reads 0x80. Writes to either have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at the 32768 Hz time-base rate |
| addr | input | 4 | Register index for reads and writes |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register, combinational |

## Verification
Read data is combinational from the registers. A written value therefore shows on `rd_data` in the cycle after the write edge, and a second rollover shows right after the edge that carries the last tick of the prescaler cycle. The update-in-progress bit follows the prescaler count with no extra delay, so it changes right after the tick that moves the count into or out of the window. The bench drives every input on the falling edge, holds each tick for exactly one rising edge, and reads on a later falling edge. It realigns the prescaler through a divider reset and release, which places it at half count with a known number of ticks left, so each rollover check lands on a computed tick.

// File: rtl/tod_calendar.sv
module tod_calendar #(
  parameter int PRESC_W   = 15,
  parameter int UIP_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic [3:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);
  localparam logic [PRESC_W-1:0] PRESC_MAX  = '1;
  localparam logic [PRESC_W-1:0] PRESC_HALF = {1'b1, {(PRESC_W-1){1'b0}}};
  localparam logic [PRESC_W-1:0] UIP_START  = PRESC_MAX - PRESC_W'(UIP_TICKS - 1);

  localparam logic [3:0] IX_SEC = 4'd0, IX_MIN = 4'd1, IX_HOUR = 4'd2, IX_DOW = 4'd3;
  localparam logic [3:0] IX_DOM = 4'd4, IX_MON = 4'd5, IX_YEAR = 4'd6, IX_CENT = 4'd7;
  localparam logic [3:0] IX_CTLA = 4'd8, IX_CTLB = 4'd9, IX_FLAG = 4'd10, IX_STAT = 4'd11;

  logic [6:0] sec_q, min_q, hour_q, dom_q, year_q, cent_q;
  logic [2:0] dow_q;
  logic [3:0] mon_q;
  logic [2:0] div_q;
  logic [3:0] rate_q;
  logic [7:0] b_q;
  logic [PRESC_W-1:0] presc_q;

  logic [6:0] n_sec, n_min, n_hour, n_dom, n_year, n_cent, mdays;
  logic [2:0] n_dow;
  logic [3:0] n_mon;
  logic [6:0] wr_val, hr_raw, hr_wr, hr12;

  wire set_mode = b_q[7];
  wire bin_mode = b_q[2];
  wire h24_mode = b_q[1];
  wire div_rst  = (div_q[2:1] == 2'b11);
  wire div_run  = (div_q <= 3'd2);
  wire running  = div_run && !set_mode;
  wire roll     = tick_32k && running && (presc_q == PRESC_MAX);
  wire uip      = running && (presc_q >= UIP_START);
  wire release_div = wr_en && (addr == IX_CTLA) && div_rst &&
                     (wr_data[6:4] <= 3'd2) && !set_mode;

  function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
    logic [6:0] t, u;
    t = v / 7'd10;
    u = v % 7'd10;
    return bin ? {1'b0, v} : {t[3:0], u[3:0]};
  endfunction

  function automatic logic [6:0] dec(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : ({3'b0, b[7:4]} * 7'd10 + {3'b0, b[3:0]});
  endfunction

  function automatic logic [6:0] month_len(input logic [3:0] m, input logic [6:0] y);
    case (m)
      4'd2:                      return (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction

  assign mdays  = month_len(mon_q, year_q);
  assign wr_val = dec(wr_data, bin_mode);
  assign hr_raw = dec(h24_mode ? wr_data : {1'b0, wr_data[6:0]}, bin_mode);
  assign hr_wr  = h24_mode ? hr_raw : (hr_raw % 7'd12) + (wr_data[7] ? 7'd12 : 7'd0);
  assign hr12   = ((hour_q % 7'd12) == 7'd0) ? 7'd12 : (hour_q % 7'd12);

  always_comb begin
    n_sec = sec_q; n_min = min_q; n_hour = hour_q; n_dow = dow_q;
    n_dom = dom_q; n_mon = mon_q; n_year = year_q; n_cent = cent_q;
    if (sec_q < 7'd59) n_sec = sec_q + 7'd1;
    else begin
      n_sec = '0;
      if (min_q < 7'd59) n_min = min_q + 7'd1;
      else begin
        n_min = '0;
        if (hour_q < 7'd23) n_hour = hour_q + 7'd1;
        else begin
          n_hour = '0;
          n_dow  = (dow_q >= 3'd7) ? 3'd1 : dow_q + 3'd1;
          if (dom_q < mdays) n_dom = dom_q + 7'd1;
          else begin
            n_dom = 7'd1;
            if (mon_q < 4'd12) n_mon = mon_q + 4'd1;
            else begin
              n_mon = 4'd1;
              if (year_q < 7'd99) n_year = year_q + 7'd1;
              else begin
                n_year = '0;
                n_cent = (cent_q >= 7'd99) ? 7'd0 : cent_q + 7'd1;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= '0; min_q <= '0; hour_q <= '0; dow_q <= 3'd1;
      dom_q <= 7'd1; mon_q <= 4'd1; year_q <= '0; cent_q <= '0;
      div_q <= 3'd2; rate_q <= 4'd6; b_q <= 8'h02; presc_q <= '0;
    end else begin
      if (release_div)                 presc_q <= PRESC_HALF;
      else if (div_rst)                presc_q <= '0;
      else if (div_run && tick_32k)    presc_q <= presc_q + 1'b1;

      if (roll) begin
        sec_q <= n_sec; min_q <= n_min; hour_q <= n_hour; dow_q <= n_dow;
        dom_q <= n_dom; mon_q <= n_mon; year_q <= n_year; cent_q <= n_cent;
      end

      if (wr_en) begin
        case (addr)
          IX_SEC:  sec_q  <= wr_val;
          IX_MIN:  min_q  <= wr_val;
          IX_HOUR: hour_q <= hr_wr;
          IX_DOW:  dow_q  <= wr_val[2:0];
          IX_DOM:  dom_q  <= wr_val;
          IX_MON:  mon_q  <= wr_val[3:0];
          IX_YEAR: year_q <= wr_val;
          IX_CENT: cent_q <= wr_val;
          IX_CTLA: begin div_q <= wr_data[6:4]; rate_q <= wr_data[3:0]; end
          IX_CTLB: b_q <= wr_data[7] ? (wr_data & 8'hEF) : wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      IX_SEC:  rd_data = enc(sec_q, bin_mode);
      IX_MIN:  rd_data = enc(min_q, bin_mode);
      IX_HOUR: rd_data = h24_mode ? enc(hour_q, bin_mode)
                                  : (enc(hr12, bin_mode) | {hour_q >= 7'd12, 7'b0});
      IX_DOW:  rd_data = enc({4'b0, dow_q}, bin_mode);
      IX_DOM:  rd_data = enc(dom_q, bin_mode);
      IX_MON:  rd_data = enc({3'b0, mon_q}, bin_mode);
      IX_YEAR: rd_data = enc(year_q, bin_mode);
      IX_CENT: rd_data = enc(cent_q, bin_mode);
      IX_CTLA: rd_data = {uip, div_q, rate_q};
      IX_CTLB: rd_data = b_q;
      IX_STAT: rd_data = 8'h80;
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/tod_calendar_checks.sv
module tod_calendar_checks #(
  parameter int PRESC_W = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_32k,
  input logic [3:0]         addr,
  input logic               wr_en,
  input logic [7:0]         rd_data,
  input logic [PRESC_W-1:0] presc_q,
  input logic [2:0]         div_q,
  input logic [7:0]         b_q,
  input logic [6:0]         sec_q,
  input logic [6:0]         min_q,
  input logic [6:0]         hour_q,
  input logic [6:0]         dom_q
);
  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    b_q[7] && !wr_en |=> $stable({sec_q, min_q, hour_q, dom_q}));

  assert_uie_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    b_q[7] |-> !b_q[4]);

  assert_presc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q[2:1] == 2'b11) && !(wr_en && addr == 4'd8) |=> (presc_q == '0));

  assert_uip_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q[2:1] == 2'b11) && (addr == 4'd8) |-> !rd_data[7]);

  assert_sec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sec_q) && !$past(wr_en) |-> $past(tick_32k) && ($past(presc_q) == '1));

  assert_flag_reg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd10) |-> (rd_data == 8'h00));

  assert_status_reg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd11) |-> (rd_data == 8'h80));
endmodule

bind tod_calendar tod_calendar_checks #(.PRESC_W(PRESC_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .addr(addr), .wr_en(wr_en),
  .rd_data(rd_data), .presc_q(presc_q), .div_q(div_q), .b_q(b_q),
  .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .dom_q(dom_q)
);

// File: tb/tod_calendar_bench.sv
`timescale 1ns/1ps
module tod_calendar_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_32k = 1'b0;
  logic [3:0] addr = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  tod_calendar #(.PRESC_W(5), .UIP_TICKS(8)) u_tod_calendar (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rd_data;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_32k = 1'b1;
      @(negedge clk); tick_32k = 1'b0;
    end
  endtask

  // divider reset then release: prescaler sits at half count, 16 ticks to rollover
  task automatic realign();
    wr(4'd8, 8'h66);
    wr(4'd8, 8'h26);
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_of(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] v, s_frozen;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 / R11 reset state
    expect_reg("R1 sec", 4'd0, 8'h00);
    expect_reg("R1 min", 4'd1, 8'h00);
    expect_reg("R1 hour", 4'd2, 8'h00);
    expect_reg("R1 dow", 4'd3, 8'h01);
    expect_reg("R1 dom", 4'd4, 8'h01);
    expect_reg("R1 mon", 4'd5, 8'h01);
    expect_reg("R1 year", 4'd6, 8'h00);
    expect_reg("R1 cent", 4'd7, 8'h00);
    expect_reg("R1 ctlA", 4'd8, 8'h26);
    expect_reg("R1 ctlB", 4'd9, 8'h02);
    expect_reg("R11 flag", 4'd10, 8'h00);
    expect_reg("R11 status", 4'd11, 8'h80);

    // R5 / R10 first second from reset, 32 ticks per second, UIP window 8
    ticks(23);
    expect_reg("R10 before window", 4'd8, 8'h26);
    ticks(1);
    expect_reg("R10 window start", 4'd8, 8'hA6);
    expect_reg("R5 not yet", 4'd0, 8'h00);
    ticks(7);
    expect_reg("R10 window end", 4'd8, 8'hA6);
    expect_reg("R5 last tick pending", 4'd0, 8'h00);
    ticks(1);
    expect_reg("R5 advanced", 4'd0, 8'h01);
    expect_reg("R10 after rollover", 4'd8, 8'h26);
    wr(4'd8, 8'hA6);
    expect_reg("R10 bit7 read-only", 4'd8, 8'h26);

    // R2 / R3 encoding sweep
    for (int s = 0; s < 60; s++) begin
      wr(4'd0, bcd(s));
      expect_reg("R2 bcd readback", 4'd0, bcd(s));
      wr(4'd9, 8'h06);
      expect_reg("R3 binary view", 4'd0, 8'(s));
      wr(4'd0, 8'((s + 7) % 60));
      wr(4'd9, 8'h02);
      expect_reg("R2 bcd view of binary write", 4'd0, bcd((s + 7) % 60));
    end

    // R4 hour format sweep in binary
    for (int h = 0; h < 24; h++) begin
      logic [7:0] h12;
      h12 = 8'((h % 12 == 0) ? 12 : h % 12) | ((h >= 12) ? 8'h80 : 8'h00);
      wr(4'd9, 8'h06);
      wr(4'd2, 8'(h));
      wr(4'd9, 8'h04);
      expect_reg("R4 12h view", 4'd2, h12);
      wr(4'd2, 8'((h + 5) % 24 % 12 == 0 ? 12 : (h + 5) % 24 % 12) | (((h + 5) % 24 >= 12) ? 8'h80 : 8'h00));
      wr(4'd9, 8'h06);
      expect_reg("R4 12h write decode", 4'd2, 8'((h + 5) % 24));
    end
    wr(4'd9, 8'h00);
    wr(4'd2, 8'h92);
    expect_reg("R4 bcd noon", 4'd2, 8'h92);
    wr(4'd9, 8'h02);
    expect_reg("R4 bcd noon in 24h", 4'd2, 8'h12);

    // R6 cascade sweep over months and years, binary 24h
    wr(4'd9, 8'h06);
    for (int y = 96; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        int d, w;
        d = days_of(m, y);
        w = (m % 7) + 1;
        // day before last: only day advances
        wr(4'd0, 8'd59); wr(4'd1, 8'd59); wr(4'd2, 8'd23); wr(4'd3, 8'(w));
        wr(4'd4, 8'(d - 1)); wr(4'd5, 8'(m)); wr(4'd6, 8'(y)); wr(4'd7, 8'd20);
        realign();
        ticks(16);
        expect_reg("R6 mid-month dom", 4'd4, 8'(d));
        expect_reg("R6 mid-month mon", 4'd5, 8'(m));
        // last day: month rollover
        wr(4'd0, 8'd59); wr(4'd1, 8'd59); wr(4'd2, 8'd23); wr(4'd3, 8'(w));
        wr(4'd4, 8'(d));
        realign();
        ticks(16);
        expect_reg("R6 sec", 4'd0, 8'd0);
        expect_reg("R6 min", 4'd1, 8'd0);
        expect_reg("R6 hour", 4'd2, 8'd0);
        expect_reg("R6 dow", 4'd3, 8'((w == 7) ? 1 : w + 1));
        expect_reg("R6 dom", 4'd4, 8'd1);
        expect_reg("R6 mon", 4'd5, 8'((m % 12) + 1));
        expect_reg("R6 year", 4'd6, 8'((m == 12) ? (y + 1) % 100 : y));
        expect_reg("R6 cent", 4'd7, 8'((m == 12 && y == 99) ? 21 : 20));
      end
    end

    // R7 set-mode freeze
    realign();
    wr(4'd9, 8'h92);
    expect_reg("R7 uie forced low", 4'd9, 8'h82);
    ticks(10);
    expect_reg("R7 no uip while set", 4'd8, 8'h26);
    rd(4'd0, s_frozen);
    ticks(64);
    expect_reg("R7 frozen", 4'd0, s_frozen);
    wr(4'd0, 8'h30);
    expect_reg("R7 write lands", 4'd0, 8'h30);
    wr(4'd9, 8'h02);
    expect_reg("R10 uip after set cleared", 4'd8, 8'hA6);
    ticks(5);
    expect_reg("R7 resumes", 4'd0, 8'h30);
    ticks(1);
    expect_reg("R7 advanced after resume", 4'd0, 8'h31);

    // R8 divider stop and reset
    wr(4'd8, 8'h36);
    ticks(64);
    expect_reg("R8 div3 stopped", 4'd0, 8'h31);
    expect_reg("R8 div3 readback", 4'd8, 8'h36);
    wr(4'd8, 8'h66);
    ticks(40);
    expect_reg("R8 reset uip clear", 4'd8, 8'h66);
    expect_reg("R8 reset stopped", 4'd0, 8'h31);

    // R9 half-second start after release
    wr(4'd8, 8'h26);
    ticks(7);
    expect_reg("R9 uip not yet", 4'd8, 8'h26);
    ticks(1);
    expect_reg("R9 uip at half plus 8", 4'd8, 8'hA6);
    ticks(7);
    expect_reg("R9 before first update", 4'd0, 8'h31);
    ticks(1);
    expect_reg("R9 first update", 4'd0, 8'h32);

    // R11 ignored writes
    wr(4'd10, 8'hFF);
    wr(4'd11, 8'h00);
    expect_reg("R11 flag after write", 4'd10, 8'h00);
    expect_reg("R11 status after write", 4'd11, 8'h80);
    expect_reg("R11 time untouched", 4'd0, 8'h32);

    done = 1'b1;
    report();
    $finish;
  end
endmodule